// File: doc/BRIEF.md
# Power-Factor Controller Mode Sequencer

This block is the mode controller of a boost power-factor-correction stage. It reads the digital outputs of the analog threshold comparators: supply turn-on and undervoltage, enable-pin sleep and wake levels, feedback open-loop, overvoltage trip and release, current-sense peak, and compensation-node low and top-of-range. From these flags it decides whether the gate driver may switch, whether the compensation node is discharged, and whether the internal bias is powered. The current mode is reported as a 3-bit code.

Each comparator flag first passes through a synchronizer with at least two stages. The gate enable is computed combinationally from the synchronized trip flags, so a fault removes the gate in the same cycle it becomes visible. The mode register follows one cycle later. The compensation node is always discharged before the controller rests in sleep or stand-by. As a result, every restart goes through soft-start.

There are two fault modes with different release rules. Overvoltage is hysteretic and waits for a separate release flag. Peak current is released cycle by cycle as soon as its flag drops. Each fault returns to the mode (soft-start or normal) it interrupted.

Top module: `pfcseq_top`

## Requirements
- R1: After reset the mode code is 0 (sleep), the gate enable is low, the compensation discharge is high and the bias enable is low.
- R2: From sleep or stand-by, the block moves to soft-start (code 2) only when three conditions hold together: supply above turn-on, feedback not open-loop, and enable above the wake level. If any one is missing, the block stays where it is. Soft-start drives the gate and bias enables high and the discharge low.
- R3: In soft-start, a top-of-range compensation flag moves the block to normal (code 3), and the gate enable stays high through the change.
- R4: A synchronized undervoltage flag puts the block into sleep on the next clock from any mode. In sleep, gate and bias are low and discharge is high.
- R5: When the enable pin drops below its sleep level, the gate turns off and the discharge is asserted while the mode code is held. Sleep is entered only once the compensation-low flag is seen.
- R6: An open-loop feedback flag moves the block to stand-by (code 1), with bias high and gate low. In stand-by the discharge is asserted until the compensation-low flag is seen.
- R7: An overvoltage trip in soft-start or normal drops the gate in the cycle the synchronized trip appears, and the mode becomes 4 one cycle later. The block stays in mode 4 after the trip clears and leaves only on the release flag, returning to the mode it was entered from.
- R8: A peak-current trip in soft-start or normal drops the gate at once and the mode becomes 5. When the trip flag clears, the block returns to the mode it was entered from.
- R9: Simultaneous conditions are resolved in this order: undervoltage or enable-sleep first, then open-loop, then overvoltage, then peak current.
- R10: Every flag passes through a two-stage synchronizer. A flag change has no effect at the outputs after one clock edge. The gate responds after two edges and the mode code after three.
- R11: The mode codes are sleep 0, stand-by 1, soft-start 2, normal 3, overvoltage 4 and peak current 5. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vcc_on_i | input | 1 | Supply above turn-on level |
| vcc_uv_i | input | 1 | Supply below undervoltage level |
| en_sleep_i | input | 1 | Enable pin below sleep level |
| en_wake_i | input | 1 | Enable pin above wake level |
| fb_open_i | input | 1 | Feedback below open-loop level |
| ovp_trip_i | input | 1 | Overvoltage trip |
| ovp_clear_i | input | 1 | Enable pin below overvoltage release level |
| ipk_trip_i | input | 1 | Current-sense peak exceeded |
| comp_low_i | input | 1 | Compensation below start level |
| comp_top_i | input | 1 | Compensation at top of range |
| gate_en_o | output | 1 | Gate driver enable |
| comp_dis_o | output | 1 | Compensation discharge request |
| bias_en_o | output | 1 | Internal bias enable |
| mode_o | output | 3 | Current mode code |

## Verification
The bench checks the overvoltage release rule. It clears the trip without raising the release flag and checks that the block stays in mode 4. A design that released on the trip alone would re-enable the gate too early. It also checks that each fault returns to the mode it came from. A peak trip taken in soft-start must come back to code 2, not 3. A design that always returned to normal would skip the remainder of soft-start.

The bench holds the compensation node high during an enable-driven shutdown. A design that entered sleep at once would leave the compensation charged, so the next start would lack soft-start. Finally, the bench counts edges from each input change. A design without the synchronizer delay, or with a registered gate kill, would show a gate or mode change one cycle off.

// File: rtl/pfcseq_pkg.sv
package pfcseq_pkg;
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      MODE_SLEEP = 3'd0,
      MODE_STBY  = 3'd1,
      MODE_SOFT  = 3'd2,
      MODE_RUN   = 3'd3,
      MODE_OVP   = 3'd4,
      MODE_IPK   = 3'd5
   } mode_e;

   typedef struct packed {
      logic vcc_on;
      logic vcc_uv;
      logic en_sleep;
      logic en_wake;
      logic fb_open;
      logic ovp_trip;
      logic ovp_clear;
      logic ipk_trip;
      logic comp_low;
      logic comp_top;
   } flags_t;

   localparam int FLAG_W = $bits(flags_t);
endpackage

// File: rtl/pfcseq_sync.sv
module pfcseq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pfcseq_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("pfcseq_sync: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pfcseq_fsm.sv
module pfcseq_fsm
   import pfcseq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  flags_t f,
   output mode_e  mode,
   output logic   sleep_pend
);
   mode_e mode_q, mode_d;
   logic  ret_run_q;
   logic  wake_ok;
   mode_e ret_mode;

   assign wake_ok    = f.vcc_on && !f.vcc_uv && !f.fb_open && f.en_wake && !f.en_sleep;
   assign ret_mode   = ret_run_q ? MODE_RUN : MODE_SOFT;
   assign sleep_pend = f.en_sleep && !f.vcc_uv && (mode_q != MODE_SLEEP);

   always_comb begin
      mode_d = mode_q;
      if (f.vcc_uv) begin
         mode_d = MODE_SLEEP;
      end else if (f.en_sleep) begin
         if (mode_q == MODE_SLEEP || f.comp_low) mode_d = MODE_SLEEP;
      end else if (f.fb_open) begin
         mode_d = MODE_STBY;
      end else begin
         case (mode_q)
            MODE_SLEEP, MODE_STBY: if (wake_ok) mode_d = MODE_SOFT;
            MODE_SOFT: begin
               if (f.ovp_trip)      mode_d = MODE_OVP;
               else if (f.ipk_trip) mode_d = MODE_IPK;
               else if (f.comp_top) mode_d = MODE_RUN;
            end
            MODE_RUN: begin
               if (f.ovp_trip)      mode_d = MODE_OVP;
               else if (f.ipk_trip) mode_d = MODE_IPK;
            end
            MODE_OVP: if (f.ovp_clear) mode_d = ret_mode;
            MODE_IPK: begin
               if (f.ovp_trip)       mode_d = MODE_OVP;
               else if (!f.ipk_trip) mode_d = ret_mode;
            end
            default: mode_d = MODE_SLEEP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_SLEEP;
         ret_run_q <= 1'b0;
      end else begin
         mode_q <= mode_d;
         if (mode_q == MODE_SOFT || mode_q == MODE_RUN) ret_run_q <= (mode_q == MODE_RUN);
      end
   end

   assign mode = mode_q;
endmodule

// File: rtl/pfcseq_outdec.sv
module pfcseq_outdec
   import pfcseq_pkg::*;
#(
   parameter bit FAST_KILL = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  mode_e  mode,
   input  flags_t f,
   input  logic   sleep_pend,
   output logic   gate_en,
   output logic   comp_dis,
   output logic   bias_en
);
   logic running;
   logic gate_c;

   assign running  = (mode == MODE_SOFT) || (mode == MODE_RUN);
   assign gate_c   = running && !f.ovp_trip && !f.ipk_trip && !f.vcc_uv
                     && !f.en_sleep && !f.fb_open;
   assign comp_dis = (mode == MODE_SLEEP) || sleep_pend
                     || ((mode == MODE_STBY) && !f.comp_low);
   assign bias_en  = (mode != MODE_SLEEP);

   generate
      if (FAST_KILL) begin : g_comb_kill
         assign gate_en = gate_c;
      end else begin : g_reg_kill
         logic gate_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) gate_q <= 1'b0;
            else        gate_q <= gate_c;
         end
         assign gate_en = gate_q;
      end
   endgenerate
endmodule

// File: rtl/pfcseq_top.sv
module pfcseq_top
   import pfcseq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit FAST_KILL   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                vcc_on_i,
   input  logic                vcc_uv_i,
   input  logic                en_sleep_i,
   input  logic                en_wake_i,
   input  logic                fb_open_i,
   input  logic                ovp_trip_i,
   input  logic                ovp_clear_i,
   input  logic                ipk_trip_i,
   input  logic                comp_low_i,
   input  logic                comp_top_i,
   output logic                gate_en_o,
   output logic                comp_dis_o,
   output logic                bias_en_o,
   output logic [MODE_W-1:0]   mode_o
);
   flags_t raw_flags;
   flags_t sflags;
   mode_e  mode;
   logic   sleep_pend;

   assign raw_flags = '{vcc_on: vcc_on_i, vcc_uv: vcc_uv_i, en_sleep: en_sleep_i,
                        en_wake: en_wake_i, fb_open: fb_open_i, ovp_trip: ovp_trip_i,
                        ovp_clear: ovp_clear_i, ipk_trip: ipk_trip_i,
                        comp_low: comp_low_i, comp_top: comp_top_i};

   pfcseq_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_flags), .q(sflags)
   );

   pfcseq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .f(sflags), .mode(mode), .sleep_pend(sleep_pend)
   );

   pfcseq_outdec #(.FAST_KILL(FAST_KILL)) u_out (
      .clk(clk), .rst_n(rst_n), .mode(mode), .f(sflags), .sleep_pend(sleep_pend),
      .gate_en(gate_en_o), .comp_dis(comp_dis_o), .bias_en(bias_en_o)
   );

   assign mode_o = mode;
endmodule

// File: rtl/pfcseq_chk.sv
module pfcseq_chk
   import pfcseq_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input flags_t f,
   input mode_e  mode,
   input logic   gate,
   input logic   cdis,
   input logic   bias
);
   logic quiet;
   assign quiet = !f.vcc_uv && !f.en_sleep && !f.fb_open;

   assert_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mode <= MODE_IPK);

   assert_sleep_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SLEEP) |-> (!gate && !bias && cdis));

   assert_uv_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      f.vcc_uv |=> (mode == MODE_SLEEP));

   assert_gate_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      gate |-> (mode == MODE_SOFT || mode == MODE_RUN));

   assert_ss_to_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SOFT && f.comp_top && quiet && !f.ovp_trip && !f.ipk_trip)
      |=> (mode == MODE_RUN));

   assert_ovp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_OVP && !f.ovp_clear && quiet) |=> (mode == MODE_OVP));

   assert_ipk_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_IPK && !f.ipk_trip && !f.ovp_trip && quiet)
      |=> (mode == MODE_SOFT || mode == MODE_RUN));

   assert_pend_dis_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (f.en_sleep && !f.vcc_uv && mode != MODE_SLEEP && !f.comp_low)
      |-> (cdis && !gate) ##1 (mode != MODE_SLEEP));

   assert_stby_bias_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_STBY) |-> (bias && !gate));
endmodule

bind pfcseq_top pfcseq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .f(sflags), .mode(mode),
   .gate(gate_en_o), .cdis(comp_dis_o), .bias(bias_en_o)
);

// File: tb/pfcseq_top_test.sv
`timescale 1ns/1ps
module pfcseq_top_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vcc_on, vcc_uv, en_sleep, en_wake, fb_open;
   logic ovp_trip, ovp_clear, ipk_trip, comp_low, comp_top;
   logic gate_en, comp_dis, bias_en;
   logic [2:0] mode;
   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   pfcseq_top uut (
      .clk(clk), .rst_n(rst_n), .vcc_on_i(vcc_on), .vcc_uv_i(vcc_uv),
      .en_sleep_i(en_sleep), .en_wake_i(en_wake), .fb_open_i(fb_open),
      .ovp_trip_i(ovp_trip), .ovp_clear_i(ovp_clear), .ipk_trip_i(ipk_trip),
      .comp_low_i(comp_low), .comp_top_i(comp_top), .gate_en_o(gate_en),
      .comp_dis_o(comp_dis), .bias_en_o(bias_en), .mode_o(mode)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_run();
      vcc_on = 1; vcc_uv = 0; en_sleep = 0; en_wake = 1; fb_open = 0;
      ovp_trip = 0; ovp_clear = 0; ipk_trip = 0; comp_low = 1; comp_top = 0;
   endtask

   task automatic to_soft();
      vcc_uv = 1; step(3);
      set_run(); step(3);
      check("R2 soft-start reached", mode, 2);
   endtask

   task automatic to_run();
      to_soft();
      comp_top = 1; step(3);
      check("R3 normal reached", mode, 3);
   endtask

   task automatic t_reset();
      check("R1 mode", mode, 0);
      check("R1 gate", gate_en, 0);
      check("R1 discharge", comp_dis, 1);
      check("R1 bias", bias_en, 0);
   endtask

   task automatic t_startup();
      set_run(); vcc_on = 0; step(4);
      check("R2 no turn-on stays sleep", mode, 0);
      vcc_on = 1; en_wake = 0; step(4);
      check("R2 no wake stays sleep", mode, 0);
      en_wake = 1; step(1);
      check("R10 one edge no change", mode, 0);
      step(1);
      check("R10 two edges mode held", mode, 0);
      step(1);
      check("R2 mode soft", mode, 2);
      check("R2 gate", gate_en, 1);
      check("R2 bias", bias_en, 1);
      check("R2 discharge off", comp_dis, 0);
      check("R11 soft code", mode, 2);
   endtask

   task automatic t_soft_to_run();
      comp_top = 1; step(2);
      check("R3 gate before switch", gate_en, 1);
      step(1);
      check("R3 mode normal", mode, 3);
      check("R3 gate after switch", gate_en, 1);
   endtask

   task automatic t_ovp();
      to_run();
      ovp_trip = 1; step(1);
      check("R10 trip one edge gate", gate_en, 1);
      step(1);
      check("R7 gate off same cycle", gate_en, 0);
      check("R7 mode not yet", mode, 3);
      step(1);
      check("R7 mode ovp", mode, 4);
      ovp_trip = 0; step(4);
      check("R7 hysteresis hold", mode, 4);
      check("R7 gate held off", gate_en, 0);
      ovp_clear = 1; step(3);
      check("R7 returns to normal", mode, 3);
      check("R7 gate back", gate_en, 1);
      ovp_clear = 0;
   endtask

   task automatic t_ipk();
      to_soft();
      ipk_trip = 1; step(2);
      check("R8 gate off", gate_en, 0);
      step(1);
      check("R8 mode ipk", mode, 5);
      ipk_trip = 0; step(3);
      check("R8 returns to soft", mode, 2);
      check("R8 gate back", gate_en, 1);
   endtask

   task automatic t_uv();
      to_run();
      vcc_uv = 1; step(3);
      check("R4 mode sleep", mode, 0);
      check("R4 bias off", bias_en, 0);
      check("R4 discharge", comp_dis, 1);
      check("R4 gate off", gate_en, 0);
   endtask

   task automatic t_en_sleep();
      to_run();
      comp_low = 0; en_sleep = 1; en_wake = 0; step(3);
      check("R5 mode held", mode, 3);
      check("R5 gate off", gate_en, 0);
      check("R5 discharge", comp_dis, 1);
      step(5);
      check("R5 still held", mode, 3);
      comp_low = 1; step(3);
      check("R5 sleep after low", mode, 0);
   endtask

   task automatic t_standby();
      to_run();
      comp_low = 0; fb_open = 1; step(3);
      check("R6 mode standby", mode, 1);
      check("R6 bias on", bias_en, 1);
      check("R6 gate off", gate_en, 0);
      check("R6 discharge", comp_dis, 1);
      comp_low = 1; step(3);
      check("R6 discharge done", comp_dis, 0);
      comp_top = 0; fb_open = 0; step(3);
      check("R2 standby exit", mode, 2);
   endtask

   task automatic t_priority();
      to_run();
      ovp_trip = 1; ipk_trip = 1; step(3);
      check("R9 ovp over ipk", mode, 4);
      ovp_trip = 0; ipk_trip = 0; ovp_clear = 1; step(3);
      check("R9 back to normal", mode, 3);
      ovp_clear = 0; ovp_trip = 1; fb_open = 1; comp_low = 0; step(3);
      check("R9 standby over ovp", mode, 1);
      vcc_uv = 1; step(3);
      check("R9 sleep over standby", mode, 0);
   endtask

   initial begin
      set_run(); vcc_on = 0; en_wake = 0;
      step(3);
      rst_n = 1;
      step(1);
      t_reset();
      t_startup();
      t_soft_to_run();
      t_ovp();
      t_ipk();
      t_uv();
      t_en_sleep();
      t_standby();
      t_priority();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #400000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule